// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Key

The block is a memory-mapped watchdog that software must service. Once enabled it counts prescaled ticks through a first stage. When that stage expires it can raise an interrupt pulse, and it then counts a second, shorter stage. If the second stage also expires, the block sets a sticky timeout flag, drives a reset request for a fixed number of clock cycles and starts over from the first stage. A service routine restarts the countdown by writing the restart bit.

The two preload registers and the restart/status register are guarded. A write to any of them takes effect only when it comes directly after two writes of fixed key values to the restart/status register. The enable register and the configuration register are not guarded. The configuration register chooses between a fast and a slow prescaler divisor and holds a two-bit interrupt mode.

Register map (word offsets on `bus_addr`): 0 first-stage preload, 1 second-stage preload, 2 restart/status, 3 enable, 4 configuration. Reads of any other offset return zero.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped, and `irq_o` and `rst_req_o` are low.
- R2: A write of 0x80 and then a write of 0x86 to offset 2, on consecutive bus accesses, opens the gate for exactly one guarded write (offsets 0, 1, 2). The next bus access of any kind closes the gate again.
- R3: A guarded write without an open gate is dropped and the register keeps its value. The gate is also broken by a wrong key, keys in the wrong order, or a read or other access between the keys.
- R4: Configuration bit 0 set selects a divisor of DIV_FAST clock cycles per tick; clear selects DIV_SLOW. A write of 1 to enable bit 0 (offset 3) while the block is stopped loads the first-stage preload and clears the prescaler, so the first tick comes a full divisor period after that write.
- R5: The first stage expires on the tick at which max(preload1, 1) ticks have elapsed. At that point `irq_o` pulses high for one cycle, unless it is masked, and the second-stage preload is loaded.
- R6: The second stage expires after max(preload2, 1) ticks. It sets the timeout flag (offset 2, bit 9), holds `rst_req_o` high for RST_CYC cycles, and restarts the first stage.
- R7: A gated write to offset 2 with bit 8 set restarts the count from the first-stage preload and clears the prescaler. A restart in the same cycle as an expiry takes precedence over it.
- R8: The timeout flag stays set until a gated write to offset 2 with bit 9 set clears it. If a clear and a new expiry fall in the same cycle, the flag ends set.
- R9: Writing 0 to enable bit 0 stops the prescaler and the counter. While stopped, neither `irq_o` nor `rst_req_o` rises.
- R10: Interrupt mode 2'b11 in configuration bits 2:1 masks the first-stage interrupt. The second-stage reset request and the timeout flag are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| irq_o | output | 1 | One-cycle first-stage interrupt pulse |
| rst_req_o | output | 1 | Reset request, high for RST_CYC cycles |

## Verification
Two events can fall in the same clock edge: the second stage expiring and software writing to clear the timeout flag. The bench starts the count at a known edge, lays the two key writes and the clearing write so that the clear lands exactly on the expiry edge, and then expects the reset request high and the flag still reading 1. A separate check makes a restart collide with the pending first-stage expiry and expects no interrupt pulse at the old expiry time, only at the time counted from the restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register word offsets
    localparam int A_PRE1  = 0;
    localparam int A_PRE2  = 1;
    localparam int A_RSTAT = 2;
    localparam int A_EN    = 3;
    localparam int A_CFG   = 4;

    // Key values for the write gate
    localparam int KEY_FIRST  = 'h80;
    localparam int KEY_SECOND = 'h86;

    // Bit positions inside restart/status register
    localparam int RESTART_BIT = 8;
    localparam int FLAG_BIT    = 9;

    // Interrupt mode that masks the first-stage interrupt
    localparam logic [1:0] IMODE_MASKED = 2'b11;

    typedef enum logic [1:0] {
        GATE_SHUT,
        GATE_HALF,
        GATE_OPEN
    } gate_state_e;

    typedef enum logic {
        STG_FIRST,
        STG_SECOND
    } stage_e;

endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_ok
);

    typedef struct packed {
        gate_state_e st;
    } gate_regs_t;

    gate_regs_t g_d, g_q;

    logic to_rstat;
    logic guarded;

    always_comb begin
        to_rstat = (addr == ADDR_W'(A_RSTAT));
        guarded  = (addr == ADDR_W'(A_PRE1)) || (addr == ADDR_W'(A_PRE2)) || to_rstat;
        wr_ok    = acc && wr && guarded && (g_q.st == GATE_OPEN);
        g_d      = g_q;
        if (acc) begin
            unique case (g_q.st)
                GATE_SHUT: g_d.st = (wr && to_rstat && wdata == DATA_W'(KEY_FIRST))
                                    ? GATE_HALF : GATE_SHUT;
                GATE_HALF: g_d.st = (wr && to_rstat && wdata == DATA_W'(KEY_SECOND))
                                    ? GATE_OPEN : GATE_SHUT;
                default:   g_d.st = GATE_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{st: GATE_SHUT};
        else        g_q <= g_d;
    end

    // R2: the gate opens only right after the second key was written
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GATE_OPEN) |-> $past(acc && wr && to_rstat && wdata == DATA_W'(KEY_SECOND)));

    // R2: an open gate serves one access and shuts
    a_r2_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GATE_OPEN && acc) |=> (g_q.st == GATE_SHUT));

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic fast,
    output logic tick
);

    localparam int PW = $clog2(DIV_SLOW);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t t_d, t_q;
    logic [PW-1:0] last;

    always_comb begin
        last = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
        tick = run && !clr && (t_q.cnt >= last);
        t_d  = t_q;
        if (clr || !run)  t_d.cnt = '0;
        else if (tick)    t_d.cnt = '0;
        else              t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{cnt: '0};
        else        t_q <= t_d;
    end

    // R4: ticks are never back to back (both divisors are at least 2)
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9: no tick while stopped
    a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             restart,
    input  logic             flag_clr,
    input  logic             tick,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic             irq,
    output logic             rst_req,
    output logic             flag
);

    localparam int RW = $clog2(RST_CYC + 1);

    typedef struct packed {
        stage_e           stg;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             flag;
        logic [RW-1:0]    rcnt;
    } ctr_regs_t;

    ctr_regs_t c_d, c_q;
    logic      due;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        due     = (c_q.cnt <= CNT_W'(1));
        if (c_q.rcnt != '0) c_d.rcnt = c_q.rcnt - 1'b1;
        if (flag_clr)       c_d.flag = 1'b0;
        if (start || restart) begin
            c_d.stg = STG_FIRST;
            c_d.cnt = pre1;
        end else if (run && tick) begin
            if (!due) begin
                c_d.cnt = c_q.cnt - 1'b1;
            end else if (c_q.stg == STG_FIRST) begin
                c_d.irq = irq_en;
                c_d.stg = STG_SECOND;
                c_d.cnt = pre2;
            end else begin
                c_d.flag = 1'b1;
                c_d.rcnt = RW'(RST_CYC);
                c_d.stg  = STG_FIRST;
                c_d.cnt  = pre1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{stg: STG_FIRST, cnt: '0, irq: 1'b0, flag: 1'b0, rcnt: '0};
        else        c_q <= c_d;
    end

    assign irq     = c_q.irq;
    assign rst_req = (c_q.rcnt != '0);
    assign flag    = c_q.flag;

    // R6: the reset request lasts more than one cycle
    a_r6_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |=> rst_req);

    // R6: the reset request starts together with the timeout flag
    a_r6_rst_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> flag);

    // R8: the flag only falls on a clear request
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R5/R10: an interrupt pulse needs the interrupt enabled and the counter running
    a_r5_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en && run));

    // R5: the interrupt is a single-cycle pulse
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a stopped counter raises nothing new
    a_r9_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (!irq && !$rose(rst_req)));

endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 32768,
    parameter int RST_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] pre1;
        logic [CNT_W-1:0] pre2;
        logic             en;
        logic             fast;
        logic [1:0]       imode;
    } cfg_regs_t;

    cfg_regs_t r_d, r_q;

    logic wr_ok;
    logic wr_any;
    logic start;
    logic restart;
    logic flag_clr;
    logic tick;
    logic flag;
    logic irq_en;

    wdt_key_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wr_ok (wr_ok)
    );

    always_comb begin
        r_d      = r_q;
        wr_any   = bus_sel && bus_wr;
        start    = 1'b0;
        restart  = 1'b0;
        flag_clr = 1'b0;
        if (wr_ok && bus_addr == ADDR_W'(A_PRE1)) r_d.pre1 = bus_wdata[CNT_W-1:0];
        if (wr_ok && bus_addr == ADDR_W'(A_PRE2)) r_d.pre2 = bus_wdata[CNT_W-1:0];
        if (wr_ok && bus_addr == ADDR_W'(A_RSTAT)) begin
            restart  = bus_wdata[RESTART_BIT];
            flag_clr = bus_wdata[FLAG_BIT];
        end
        if (wr_any && bus_addr == ADDR_W'(A_EN)) begin
            r_d.en = bus_wdata[0];
            start  = bus_wdata[0] && !r_q.en;
        end
        if (wr_any && bus_addr == ADDR_W'(A_CFG)) begin
            r_d.fast  = bus_wdata[0];
            r_d.imode = bus_wdata[2:1];
        end
        irq_en = (r_q.imode != IMODE_MASKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pre1: '0, pre2: '0, en: 1'b0, fast: 1'b0, imode: 2'b00};
        else        r_q <= r_d;
    end

    wdt_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.en),
        .clr   (start || restart),
        .fast  (r_q.fast),
        .tick  (tick)
    );

    wdt_stage_ctr #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.en),
        .start    (start),
        .restart  (restart),
        .flag_clr (flag_clr),
        .tick     (tick),
        .irq_en   (irq_en),
        .pre1     (r_q.pre1),
        .pre2     (r_q.pre2),
        .irq      (irq_o),
        .rst_req  (rst_req_o),
        .flag     (flag)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(A_PRE1):  bus_rdata[CNT_W-1:0] = r_q.pre1;
            ADDR_W'(A_PRE2):  bus_rdata[CNT_W-1:0] = r_q.pre2;
            ADDR_W'(A_RSTAT): bus_rdata[FLAG_BIT]  = flag;
            ADDR_W'(A_EN):    bus_rdata[0]         = r_q.en;
            ADDR_W'(A_CFG):   bus_rdata[2:0]       = {r_q.imode, r_q.fast};
            default:          bus_rdata            = '0;
        endcase
    end

    // R3: preloads change only through a gated write
    a_r3_pre1_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(r_q.pre1));

    a_r3_pre2_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(r_q.pre2));

endmodule

// File: tb/sim_wdt_dual_stage.sv
module sim_wdt_dual_stage;

    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;
    logic          rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_dual_stage #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(16),
        .DIV_FAST(4), .DIV_SLOW(16), .RST_CYC(5)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_sel = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // each write occupies exactly one rising edge
    task automatic wr(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic unlock();
        wr(2, 32'h80);
        wr(2, 32'h86);
    endtask

    task automatic gated_wr(input int a, input logic [31:0] d);
        unlock();
        wr(a, d);
    endtask

    // samples n cycles after the last write edge; irq expected at i1/i2, reset in [r0,r1]
    task automatic watch(input string req, input int n, input int i1, input int i2,
                         input int r0, input int r1);
        int bad = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (irq_o !== ((k == i1) || (k == i2))) bad++;
            if (rst_req_o !== ((k >= r0) && (k <= r1))) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R1 register zero", v, 0);
        end
        chk("R1 irq low", irq_o, 0);
        chk("R1 reset request low", rst_req_o, 0);
    endtask

    task automatic t_gate_open();
        logic [31:0] v;
        do_reset();
        gated_wr(0, 7);
        rd(0, v);
        chk("R2 gated write to preload1", v, 7);
        wr(1, 3);
        rd(1, v);
        chk("R2 gate closes after one write", v, 0);
        gated_wr(1, 2);
        rd(1, v);
        chk("R2 second gated write", v, 2);
    endtask

    task automatic t_gate_broken();
        logic [31:0] v;
        wr(0, 9);
        rd(0, v);
        chk("R3 write without keys dropped", v, 7);
        wr(2, 32'h80); wr(2, 32'h85); wr(0, 9);
        rd(0, v);
        chk("R3 wrong second key", v, 7);
        wr(2, 32'h80); rd(3, v); wr(2, 32'h86); wr(0, 9);
        rd(0, v);
        chk("R3 read between keys", v, 7);
        wr(2, 32'h86); wr(2, 32'h80); wr(0, 9);
        rd(0, v);
        chk("R3 keys reversed", v, 7);
        wr(2, 32'h80); wr(4, 0); wr(2, 32'h86); wr(1, 9);
        rd(1, v);
        chk("R3 other write between keys", v, 2);
    endtask

    task automatic t_stages();
        logic [31:0] v;
        do_reset();
        gated_wr(0, 3);
        gated_wr(1, 2);
        wr(4, 1);
        wr(3, 1);
        // irq at 3*4, reset at 5*4 for 5 cycles, next irq at 20+12
        watch("R5 R6 stage timing", 33, 12, 32, 20, 24);
        rd(2, v);
        chk("R6 timeout flag set", v[9], 1);
    endtask

    task automatic t_slow();
        do_reset();
        gated_wr(0, 2);
        gated_wr(1, 1);
        wr(4, 0);
        wr(3, 1);
        watch("R4 slow divisor", 40, 32, -1, 48, 48);
    endtask

    task automatic t_restart();
        do_reset();
        gated_wr(0, 3);
        gated_wr(1, 2);
        wr(4, 1);
        wr(3, 1);
        repeat (5) @(negedge clk);
        gated_wr(2, 32'h100);
        // the old expiry would have fallen 4 cycles after the restart
        watch("R7 restart reloads preload1", 13, 12, -1, 99, 99);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        do_reset();
        gated_wr(0, 2);
        gated_wr(1, 2);
        wr(4, 1);
        wr(3, 1);
        repeat (13) @(negedge clk);
        gated_wr(2, 32'h200);   // lands on the second-stage expiry edge
        chk("R8 reset request on collision edge", rst_req_o, 1);
        rd(2, v);
        chk("R8 set wins over clear", v[9], 1);
        wr(2, 32'h200);
        rd(2, v);
        chk("R8 clear without keys ignored", v[9], 1);
        gated_wr(2, 32'h200);
        rd(2, v);
        chk("R8 gated clear", v[9], 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int seen = 0;
        do_reset();
        gated_wr(0, 3);
        gated_wr(1, 1);
        wr(4, 1);
        wr(3, 1);
        repeat (6) @(negedge clk);
        wr(3, 0);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (irq_o || rst_req_o) seen++;
        end
        chk("R9 stopped watchdog quiet", seen, 0);
        rd(2, v);
        chk("R9 flag stays clear when stopped", v[9], 0);
        wr(3, 1);
        watch("R4 re-enable clears prescaler", 13, 12, -1, 99, 99);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        do_reset();
        gated_wr(0, 2);
        gated_wr(1, 1);
        wr(4, 7);
        wr(3, 1);
        watch("R10 masked irq, reset kept", 18, -1, -1, 12, 16);
        rd(2, v);
        chk("R10 flag set with irq masked", v[9], 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_gate_open();
        t_gate_broken();
        t_stages();
        t_slow();
        t_restart();
        t_collision();
        t_stop();
        t_masked();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule